// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device side of an ATA task-file register set. A host reaches it through a small I/O port interface. The interface has a 3-bit register offset, separate read and write strobes, a byte-wide write path and a 16-bit read path. The block holds the sector count, the three address bytes and the device/head register. It shows a status byte on reads of the command offset and takes command codes on writes to that offset.

Four commands are decoded. IDENTIFY serves 256 programmed-I/O words from an internal table. That table carries a serial string, a version string and a write-cache-enabled flag. FLUSH CACHE holds the device busy until an outside completion pulse arrives. READ DMA and WRITE DMA go to an external DMA engine through a start pulse. The start pulse carries the direction, a 24-bit block address and a sector count, and a done pulse ends the command. Every completed command raises the interrupt line, and any status read lowers it.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status reads 0x40 (DRDY only), the interrupt line is low, and the count, address and device registers read 0.
- R2: Register offsets are: count 2, address low 3, address middle 4, address high 5, device 6. Each one reads back the byte last written in its low 8 bits. In the device register, bit 0x10 selects device 1 and bit 0x40 selects LBA addressing. After a write of 0x40, the read-back shows bit 0x10 clear.
- R3: Status bits are BSY 0x80, DRDY 0x40, DF 0x20, DRQ 0x08 and ERR 0x01, and DRDY is always set. A command code other than 0xC8, 0xCA, 0xE7 or 0xEC gives status 0x41 and raises the interrupt. The next accepted command clears ERR.
- R4: After IDENTIFY (0xEC), the interrupt rises and status reads 0x48 until 256 words have been read from offset 0. Status then reads 0x40. Words 10–19 hold the 20-character serial string and words 23–26 hold the 8-character version string, two characters per word with the first in the high byte. Word 85 is 0x0020, and every other word is 0.
- R5: FLUSH CACHE (0xE7) pulses `flush_start` for one cycle, in the cycle after the command write. Status then reads 0xC0 with no interrupt until `flush_done` arrives. After that, status reads 0x40 and the interrupt is high.
- R6: READ DMA (0xC8) and WRITE DMA (0xCA) pulse `dma_start` for one cycle, in the cycle after the command write. With the pulse, `dma_read` is 1 for 0xC8 and 0 for 0xCA, and `dma_lba` is {high, middle, low}. Status reads 0xC0 until `dma_done` arrives. After that, status reads 0x40 and the interrupt is high.
- R7: A sector count register of 0 is presented on `dma_count` as 256. Any other value N is presented as N.
- R8: A read of offset 7 lowers the interrupt line. Reads of other offsets leave it unchanged.
- R9: While status shows BSY or DRQ, command writes are ignored. While status shows BSY, register writes are also ignored.
- R10: A read of offset 0 outside an IDENTIFY transfer returns 0 and leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 3 | Register offset |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 16 | Read data for the addressed register (combinational) |
| intrq | output | 1 | Interrupt request |
| dma_start | output | 1 | One-cycle request to the DMA engine |
| dma_read | output | 1 | 1 = device to memory (READ DMA) |
| dma_lba | output | 24 | Block address {high, middle, low} |
| dma_count | output | 9 | Sector count, with 0 mapped to 256 |
| dma_done | input | 1 | DMA engine finished the transfer |
| flush_start | output | 1 | One-cycle request to the medium to flush |
| flush_done | input | 1 | Flush finished |

## Verification
The assertions assume that the host never drives the read and write strobes in the same cycle. They also assume that `dma_done` and `flush_done` arrive only while the matching command is pending. A done pulse landing on a status read could otherwise blur the rule that a status read clears the interrupt. The bench keeps to these assumptions: its tasks perform one access each, and it pulses a done input only after it has seen the matching start pulse. It also drives a command write during an IDENTIFY transfer and a register write during a flush, so that the checks on ignored accesses run against real stimulus.

// File: rtl/ata_tf_pkg.sv
// Shared constants and types for the task-file controller.
// Assumes: a 3-bit register offset and byte-wide task-file registers.
package ata_tf_pkg;
    localparam logic [7:0] ST_BSY  = 8'h80;
    localparam logic [7:0] ST_DRDY = 8'h40;
    localparam logic [7:0] ST_DF   = 8'h20;
    localparam logic [7:0] ST_DRQ  = 8'h08;
    localparam logic [7:0] ST_ERR  = 8'h01;

    localparam logic [7:0] OP_DMA_IN   = 8'hC8;
    localparam logic [7:0] OP_DMA_OUT  = 8'hCA;
    localparam logic [7:0] OP_FLUSH    = 8'hE7;
    localparam logic [7:0] OP_IDENTIFY = 8'hEC;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_COUNT = 3'd2;
    localparam logic [2:0] OFS_ADR0  = 3'd3;
    localparam logic [2:0] OFS_ADR1  = 3'd4;
    localparam logic [2:0] OFS_ADR2  = 3'd5;
    localparam logic [2:0] OFS_DEV   = 3'd6;
    localparam logic [2:0] OFS_CMD   = 3'd7;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PIO   = 2'd1,
        PH_FLUSH = 2'd2,
        PH_DMA   = 2'd3
    } phase_t;
endpackage

// File: rtl/ata_id_rom.sv
// Identification word table, computed from parameters rather than stored.
// Assumes: SERIAL is 20 characters and VERSION is 8, with the first
// character in the most significant byte of each string.
module ata_id_rom #(
    parameter int          ID_WORDS = 256,
    parameter int          IDX_W    = $clog2(ID_WORDS),
    parameter logic [159:0] SERIAL  = "TF-UNIT-0001        ",
    parameter logic [63:0]  VERSION = "REV-1.0 "
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);
    localparam int SER_FIRST = 10;
    localparam int SER_LAST  = SER_FIRST + 9;
    localparam int VER_FIRST = 23;
    localparam int VER_LAST  = VER_FIRST + 3;
    localparam int CACHE_W   = 85;

    // Select the word contents for the current index.
    always_comb begin
        int w;
        w    = int'(idx);
        word = 16'h0000;
        if (w >= SER_FIRST && w <= SER_LAST)
            word = SERIAL[159 - 16*(w - SER_FIRST) -: 16];
        else if (w >= VER_FIRST && w <= VER_LAST)
            word = VERSION[63 - 16*(w - VER_FIRST) -: 16];
        else if (w == CACHE_W)
            word = 16'h0020;
    end
endmodule

// File: rtl/ata_tf_seq.sv
// Command sequencer: decodes command codes, steps the phase, builds the
// status byte, holds the interrupt and counts identification words.
// Assumes: only one of cmd_we / stat_rd / data_rd is active per cycle.
module ata_tf_seq
    import ata_tf_pkg::*;
#(
    parameter int ID_WORDS = 256,
    parameter int IDX_W    = $clog2(ID_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic             stat_rd,
    input  logic             data_rd,
    input  logic             dma_done,
    input  logic             flush_done,
    output logic [7:0]       status,
    output logic             intrq,
    output logic [IDX_W-1:0] word_idx,
    output logic             dma_start,
    output logic             dma_is_read,
    output logic             flush_start,
    output logic             pio_active
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

    phase_t phase_q;
    logic   err_q;

    // Phase, error, interrupt and word-index state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            err_q       <= 1'b0;
            intrq       <= 1'b0;
            word_idx    <= '0;
            dma_start   <= 1'b0;
            dma_is_read <= 1'b0;
            flush_start <= 1'b0;
        end else begin
            dma_start   <= 1'b0;
            flush_start <= 1'b0;
            if (stat_rd)
                intrq <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (cmd_we) begin
                    err_q <= 1'b0;
                    unique case (cmd_code)
                        OP_DMA_IN, OP_DMA_OUT: begin
                            phase_q     <= PH_DMA;
                            dma_start   <= 1'b1;
                            dma_is_read <= (cmd_code == OP_DMA_IN);
                        end
                        OP_FLUSH: begin
                            phase_q     <= PH_FLUSH;
                            flush_start <= 1'b1;
                        end
                        OP_IDENTIFY: begin
                            phase_q  <= PH_PIO;
                            word_idx <= '0;
                            intrq    <= 1'b1;
                        end
                        default: begin
                            err_q <= 1'b1;
                            intrq <= 1'b1;
                        end
                    endcase
                end
                PH_PIO: if (data_rd) begin
                    word_idx <= word_idx + 1'b1;
                    if (word_idx == LAST_IDX)
                        phase_q <= PH_IDLE;
                end
                PH_FLUSH: if (flush_done) begin
                    phase_q <= PH_IDLE;
                    intrq   <= 1'b1;
                end
                PH_DMA: if (dma_done) begin
                    phase_q <= PH_IDLE;
                    intrq   <= 1'b1;
                end
            endcase
        end
    end

    // Status byte derived from the phase and the error flag.
    always_comb begin
        status = ST_DRDY;
        if (phase_q == PH_FLUSH || phase_q == PH_DMA)
            status = status | ST_BSY;
        if (phase_q == PH_PIO)
            status = status | ST_DRQ;
        if (err_q)
            status = status | ST_ERR;
    end

    // Flag for the read mux: the data port serves table words.
    assign pio_active = (phase_q == PH_PIO);
endmodule

// File: rtl/ata_taskfile_ctrl.sv
// Task-file register controller top: register file, offset decode and
// read mux around the command sequencer and the identification table.
// Assumes: the host issues at most one access per cycle.
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int           ID_WORDS = 256,
    parameter logic [159:0] SERIAL   = "TF-UNIT-0001        ",
    parameter logic [63:0]  VERSION  = "REV-1.0 "
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [15:0] io_rdata,
    output logic        intrq,
    output logic        dma_start,
    output logic        dma_read,
    output logic [23:0] dma_lba,
    output logic [8:0]  dma_count,
    input  logic        dma_done,
    output logic        flush_start,
    input  logic        flush_done
);
    localparam int IDX_W = $clog2(ID_WORDS);

    logic [7:0]       count_q, adr0_q, adr1_q, adr2_q, dev_q;
    logic [7:0]       status_w;
    logic [IDX_W-1:0] idx_w;
    logic [15:0]      rom_word;
    logic             pio_w;
    logic             cmd_we, stat_rd, data_rd, busy;

    // Strobe decode.
    assign cmd_we  = io_wr && (io_addr == OFS_CMD);
    assign stat_rd = io_rd && (io_addr == OFS_CMD);
    assign data_rd = io_rd && (io_addr == OFS_DATA) && pio_w;
    assign busy    = status_w[7];

    // Task-file registers, frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            adr0_q  <= '0;
            adr1_q  <= '0;
            adr2_q  <= '0;
            dev_q   <= '0;
        end else if (io_wr && !busy) begin
            unique case (io_addr)
                OFS_COUNT: count_q <= io_wdata;
                OFS_ADR0:  adr0_q  <= io_wdata;
                OFS_ADR1:  adr1_q  <= io_wdata;
                OFS_ADR2:  adr2_q  <= io_wdata;
                OFS_DEV:   dev_q   <= io_wdata;
                default:   ;
            endcase
        end
    end

    // Read mux for the addressed register.
    always_comb begin
        unique case (io_addr)
            OFS_DATA:  io_rdata = pio_w ? rom_word : 16'h0000;
            OFS_COUNT: io_rdata = {8'h00, count_q};
            OFS_ADR0:  io_rdata = {8'h00, adr0_q};
            OFS_ADR1:  io_rdata = {8'h00, adr1_q};
            OFS_ADR2:  io_rdata = {8'h00, adr2_q};
            OFS_DEV:   io_rdata = {8'h00, dev_q};
            OFS_CMD:   io_rdata = {8'h00, status_w};
            default:   io_rdata = 16'h0000;
        endcase
    end

    assign dma_lba   = {adr2_q, adr1_q, adr0_q};
    assign dma_count = (count_q == 8'h00) ? 9'd256 : {1'b0, count_q};

    ata_tf_seq #(.ID_WORDS(ID_WORDS), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_code    (io_wdata),
        .stat_rd     (stat_rd),
        .data_rd     (data_rd),
        .dma_done    (dma_done),
        .flush_done  (flush_done),
        .status      (status_w),
        .intrq       (intrq),
        .word_idx    (idx_w),
        .dma_start   (dma_start),
        .dma_is_read (dma_read),
        .flush_start (flush_start),
        .pio_active  (pio_w)
    );

    ata_id_rom #(.ID_WORDS(ID_WORDS), .IDX_W(IDX_W),
                 .SERIAL(SERIAL), .VERSION(VERSION)) u_rom (
        .idx  (idx_w),
        .word (rom_word)
    );
endmodule

// File: rtl/ata_tf_checker.sv
// Property checker for the task-file controller, bound to the top.
// Assumes: strobes are exclusive and done pulses only answer a request.
module ata_tf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] io_addr,
    input logic       io_rd,
    input logic       io_wr,
    input logic [7:0] status,
    input logic       intrq,
    input logic       dma_start,
    input logic       flush_start,
    input logic       dma_done,
    input logic       flush_done
);
    p_drdy_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[6]);

    p_no_bsy_with_drq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[7] && status[3]));

    p_flush_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_start |-> (status[7] && !status[3]));

    p_start_is_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);

    p_start_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> status[7]);

    p_status_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == 3'd7 && !dma_done && !flush_done) |=> !intrq);

    p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_start, flush_start}));
endmodule

bind ata_taskfile_ctrl ata_tf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .status      (status_w),
    .intrq       (intrq),
    .dma_start   (dma_start),
    .flush_start (flush_start),
    .dma_done    (dma_done),
    .flush_done  (flush_done)
);

// File: tb/ata_taskfile_ctrl_tb.sv
// Directed bench for the task-file controller: one task per scenario.
module ata_taskfile_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] io_rdata;
    logic        intrq, dma_start, dma_read, flush_start;
    logic [23:0] dma_lba;
    logic [8:0]  dma_count;
    logic        dma_done = 1'b0, flush_done = 1'b0;

    int n_chk = 0, n_bad = 0;
    int n_dma = 0, n_flush = 0;
    logic        cap_read;
    logic [23:0] cap_lba;
    logic [8:0]  cap_count;
    bit          done_flag = 0;

    localparam logic [159:0] SER = "TF-UNIT-0001        ";
    localparam logic [63:0]  VER = "REV-1.0 ";

    always #2 clk = ~clk;

    ata_taskfile_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .intrq(intrq), .dma_start(dma_start), .dma_read(dma_read),
        .dma_lba(dma_lba), .dma_count(dma_count), .dma_done(dma_done),
        .flush_start(flush_start), .flush_done(flush_done)
    );

    // Record request pulses away from the active edge.
    always @(negedge clk) begin
        if (dma_start) begin
            n_dma++;
            cap_read  = dma_read;
            cap_lba   = dma_lba;
            cap_count = dma_count;
        end
        if (flush_start) n_flush++;
    end

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 v = io_rdata;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    function automatic logic [15:0] exp_word(input int i);
        if (i >= 10 && i <= 19) return SER[159 - 16*(i-10) -: 16];
        if (i >= 23 && i <= 26) return VER[63 - 16*(i-23) -: 16];
        if (i == 85) return 16'h0020;
        return 16'h0000;
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd7, v); chk(v, 8'h40, "R1 status");
        chk(intrq, 0, "R1 intrq");
        rd(3'd2, v); chk(v, 0, "R1 count");
        rd(3'd6, v); chk(v, 0, "R1 device");
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(3'd2, 8'h05); wr(3'd3, 8'h11); wr(3'd4, 8'h22); wr(3'd5, 8'h33);
        wr(3'd6, 8'h50);
        rd(3'd2, v); chk(v, 8'h05, "R2 count");
        rd(3'd3, v); chk(v, 8'h11, "R2 adr low");
        rd(3'd4, v); chk(v, 8'h22, "R2 adr mid");
        rd(3'd5, v); chk(v, 8'h33, "R2 adr high");
        rd(3'd6, v); chk(v, 8'h50, "R2 device dev1");
        wr(3'd6, 8'h40);
        rd(3'd6, v); chk(v & 16'h10, 0, "R2 device dev0");
        rd(3'd0, v); chk(v, 0, "R10 idle data");
        rd(3'd7, v); chk(v, 8'h40, "R10 status unchanged");
    endtask

    task automatic t_unknown();
        logic [15:0] v;
        wr(3'd7, 8'h00);
        chk(intrq, 1, "R3 irq on bad cmd");
        rd(3'd2, v);
        chk(intrq, 1, "R8 other read keeps irq");
        rd(3'd7, v); chk(v, 8'h41, "R3 err status");
        chk(intrq, 0, "R8 status read clears");
    endtask

    task automatic t_identify();
        logic [15:0] v;
        int bad_st = 0, bad_wd = 0;
        int fl0;
        fl0 = n_flush;
        wr(3'd7, 8'hEC);
        chk(intrq, 1, "R4 irq on identify");
        rd(3'd0, v); chk(v, exp_word(0), "R4 word 0");
        chk(intrq, 1, "R8 data read keeps irq");
        for (int i = 1; i < 256; i++) begin
            rd(3'd7, v); if (v != 16'h48) bad_st++;
            if (i == 100) begin
                wr(3'd7, 8'hE7);
                rd(3'd7, v); chk(v, 8'h48, "R9 cmd ignored in PIO");
            end
            rd(3'd0, v);
            if (v != exp_word(i)) begin
                bad_wd++;
                $display("FAIL R4 word %0d: actual 0x%0h expected 0x%0h", i, v, exp_word(i));
            end
        end
        chk(bad_st, 0, "R4 status during transfer");
        n_chk++; if (bad_wd != 0) n_bad++;
        chk(n_flush, fl0, "R9 no flush request");
        rd(3'd7, v); chk(v, 8'h40, "R4 status after 256");
        rd(3'd0, v); chk(v, 0, "R10 data after transfer");
    endtask

    task automatic t_flush();
        logic [15:0] v;
        int fl0;
        fl0 = n_flush;
        wr(3'd3, 8'h11);
        wr(3'd7, 8'hE7);
        settle();
        chk(n_flush, fl0 + 1, "R5 one flush pulse");
        rd(3'd7, v); chk(v, 8'hC0, "R5 busy status");
        wr(3'd3, 8'hAA);
        repeat (10) settle();
        chk(n_flush, fl0 + 1, "R5 single pulse");
        chk(intrq, 0, "R5 no irq while pending");
        rd(3'd7, v); chk(v, 8'hC0, "R5 still busy");
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0; #1;
        chk(intrq, 1, "R5 irq on done");
        rd(3'd7, v); chk(v, 8'h40, "R5 status after done");
        rd(3'd3, v); chk(v, 8'h11, "R9 write ignored while busy");
    endtask

    task automatic t_dma(input logic [7:0] op, input logic [7:0] cnt,
                         input logic [23:0] lba, input int exp_cnt);
        logic [15:0] v;
        int d0;
        d0 = n_dma;
        wr(3'd2, cnt); wr(3'd3, lba[7:0]); wr(3'd4, lba[15:8]); wr(3'd5, lba[23:16]);
        wr(3'd7, op);
        settle();
        chk(n_dma, d0 + 1, "R6 dma pulse");
        chk(cap_read, (op == 8'hC8), "R6 direction");
        chk(cap_lba, lba, "R6 lba");
        chk(cap_count, exp_cnt, "R7 count");
        rd(3'd7, v); chk(v, 8'hC0, "R6 busy status (R3 err cleared)");
        repeat (5) settle();
        chk(n_dma, d0 + 1, "R6 single pulse");
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0; #1;
        chk(intrq, 1, "R6 irq on done");
        rd(3'd7, v); chk(v, 8'h40, "R6 status after done");
        chk(intrq, 0, "R8 cleared after dma");
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_unknown();
        t_dma(8'hC8, 8'h00, 24'h123456, 256);
        t_dma(8'hCA, 8'h03, 24'hABCDEF, 3);
        t_identify();
        t_flush();
        finish_run();
    end
endmodule